// File: doc/BRIEF.md
# Mode-Switchable Receive Queue

This block is the receive side of a 16550-style serial port. It keeps incoming bytes in a queue. The queue holds one byte in legacy mode and sixteen bytes once software sets the enable bit of the FIFO control register. Bytes come from the receiver input. When the loopback input is high, they come instead from CPU writes to the data offset. The CPU removes bytes by reading the data offset. It reads the line status offset to see whether data is waiting and whether a byte was lost.

The control register drives the queue. Flipping its enable bit empties the queue and resizes it. With the enable bit set, a receiver-reset bit empties the queue. Line status reports data-ready and a sticky overrun flag. The two transmitter-empty bits are tied to one. Serial framing, baud timing, trigger-level interrupts and the receive timeout are handled elsewhere.

Top module: `uart_rxq`

## Requirements
- R1: After reset the queue is empty with a capacity of one byte, `ctrl_q` is 0x00, `rx_ready` is 1 and a line status read returns 0x60.
- R2: Bytes leave the queue in arrival order. The capacity is 16 when control bit 0 is set and 1 when it is clear. A data read at offset 0 returns the oldest byte and removes it.
- R3: A control write at offset 2 whose bit 0 differs from the stored bit 0 empties the queue and applies the new capacity. This clear wins over a receiver byte offered in the same cycle.
- R4: A control write with bit 0 clear stores 0x00, whatever its other bits are.
- R5: A control write with bit 0 set and bit 1 set empties the queue. With bit 0 set, only bits 0, 3, 6 and 7 of the written value are stored.
- R6: While `loopback` is high, a data write at offset 0 pushes its byte and `rx_valid` is ignored. A loopback write to a full queue drops the byte and sets overrun.
- R7: While `loopback` is low, `rx_ready` equals "queue not full". A receiver byte offered to a full queue, with no pop in the same cycle, is dropped and leaves overrun unchanged.
- R8: A read at offset 5 returns bit 0 = queue not empty, bit 1 = overrun, bits 5 and 6 = 1, and all other bits 0.
- R9: A line status read returns the value before the read and then clears overrun. Writes to offset 5 change nothing.
- R10: A data read from an empty queue returns 0xFF and the queue stays empty.
- R11: A receiver byte and a data read in the same cycle on a full queue are both accepted. The queue stays full and overrun does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loopback | input | 1 | Selects CPU data writes as the byte source |
| rx_valid | input | 1 | Receiver offers a byte this cycle |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Queue has room for a byte |
| wr_en | input | 1 | CPU register write strobe |
| rd_en | input | 1 | CPU register read strobe |
| addr | input | 3 | Register offset: 0 data, 2 control, 5 line status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rd_en` |
| ctrl_q | output | 8 | Stored control value |

## Verification
Two pairs of events can meet in one edge. The first pair is a receiver byte and a CPU data read. The bench forces this case on a full queue in both capacities and expects the read to return the old head byte. The queue must then hold the new byte at the tail, stay full and report no overrun. The second pair is a receiver byte and a control write. The bench issues control writes together with receiver bytes. It expects the byte to be gone when the write toggles the enable bit or resets the receiver, and to be queued otherwise. Constrained random traffic mixes both pairs with pops, status reads and loopback writes against a queue model kept in the bench.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFF_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_LSR  = 3'd5;

  // control register bit positions
  localparam int CB_EN    = 0;
  localparam int CB_RXRST = 1;
  localparam logic [BYTE_W-1:0] CTRL_KEEP = 8'hC9;

  // line status bit positions
  localparam int LB_DR   = 0;
  localparam int LB_OVR  = 1;
  localparam int LB_THRE = 5;
  localparam int LB_TEMT = 6;

  typedef struct packed {
    logic clr;
    logic wide;
  } q_ctl_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          wide_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          push_ok_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d, cap;
  logic          do_pop, do_push;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p,
                                         input logic [CW-1:0] c);
    if (CW'(p) == c - 1'b1) return '0;
    return p + 1'b1;
  endfunction

  assign cap       = wide_i ? CW'(DEPTH) : CW'(1);
  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q >= cap);
  assign do_pop    = pop_i && !empty_o;
  assign do_push   = push_i && (!full_o || do_pop);
  assign push_ok_o = do_push && !clr_i;
  assign head_o    = empty_o ? {DW{1'b1}} : mem[rd_q];

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_pop)  rd_d = step(rd_q, cap);
      if (do_push) wr_d = step(wr_q, cap);
      if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_we;
    assign slot_we = push_ok_o && (wr_q == PW'(i));
    always_ff @(posedge clk) begin
      if (slot_we) mem[i] <= push_data_i;
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_i && !push_i && !clr_i) |=> empty_o);
  assert_full_swap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && pop_i && push_i && !clr_i) |=> full_o);
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import uart_rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] ctrl_o,
  output q_ctl_t            qctl_o
);
  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_we, flip, rx_reset;

  assign flip     = wr_i && (wdata_i[CB_EN] != ctrl_q[CB_EN]);
  assign rx_reset = wr_i && wdata_i[CB_EN] && wdata_i[CB_RXRST];
  assign ctrl_we  = wr_i;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = wdata_i[CB_EN] ? (wdata_i & CTRL_KEEP) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  assign ctrl_o      = ctrl_q;
  assign qctl_o.clr  = flip || rx_reset;
  assign qctl_o.wide = ctrl_q[CB_EN];

  assert_disable_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !wdata_i[CB_EN]) |=> (ctrl_o == '0));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ctrl_o));
endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import uart_rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              lsr_rd_i,
  input  logic              nonempty_i,
  output logic [BYTE_W-1:0] lsr_o
);
  logic ovr_q, ovr_d, ovr_we;

  assign ovr_we = set_i || lsr_rd_i;

  always_comb begin
    ovr_d = ovr_q;
    if (set_i)         ovr_d = 1'b1;
    else if (lsr_rd_i) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovr_q <= 1'b0;
    else if (ovr_we) ovr_q <= ovr_d;
  end

  always_comb begin
    lsr_o          = '0;
    lsr_o[LB_DR]   = nonempty_i;
    lsr_o[LB_OVR]  = ovr_q;
    lsr_o[LB_THRE] = 1'b1;
    lsr_o[LB_TEMT] = 1'b1;
  end

  assert_ovr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd_i && !set_i) |=> !lsr_o[LB_OVR]);
  assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_o[LB_OVR] && !lsr_rd_i) |=> lsr_o[LB_OVR]);
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loopback,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_ready,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] ctrl_q
);
  q_ctl_t            qctl;
  logic              data_wr, ctrl_wr, data_rd, lsr_rd;
  logic              push, pop, empty, full, push_ok, ovr_set;
  logic [BYTE_W-1:0] push_data, head, lsr;

  assign data_wr = wr_en && (addr == OFF_DATA);
  assign ctrl_wr = wr_en && (addr == OFF_CTRL);
  assign data_rd = rd_en && (addr == OFF_DATA);
  assign lsr_rd  = rd_en && (addr == OFF_LSR);

  assign push      = loopback ? data_wr : rx_valid;
  assign push_data = loopback ? wdata   : rx_byte;
  assign pop       = data_rd;
  assign ovr_set   = loopback && data_wr && !push_ok && !qctl.clr;
  assign rx_ready  = !full;

  rxq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (ctrl_wr),
    .wdata_i (wdata),
    .ctrl_o  (ctrl_q),
    .qctl_o  (qctl)
  );

  rxq_store #(.DW(BYTE_W), .DEPTH(DEPTH)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (qctl.clr),
    .wide_i      (qctl.wide),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop),
    .head_o      (head),
    .empty_o     (empty),
    .full_o      (full),
    .push_ok_o   (push_ok)
  );

  rxq_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (ovr_set),
    .lsr_rd_i   (lsr_rd),
    .nonempty_i (!empty),
    .lsr_o      (lsr)
  );

  always_comb begin
    rdata = '0;
    if (data_rd)     rdata = head;
    else if (lsr_rd) rdata = lsr;
  end

  assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    qctl.clr |=> empty);
  assert_lb_ignores_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loopback && empty && rx_valid && !wr_en && !qctl.clr) |=> empty);
  assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!loopback && full && rx_valid && !rd_en && !wr_en) |=> (full && !lsr[LB_OVR] == !$past(lsr[LB_OVR])));
endmodule

// File: tb/sim_uart_rxq.sv
`timescale 1ns/1ps
module sim_uart_rxq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       loopback = 1'b0, rx_valid = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rx_byte = '0, wdata = '0, rdata, ctrl_q;
  logic [2:0] addr = '0;
  logic       rx_ready;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  byte unsigned q[$];
  bit           m_ovr = 0;
  logic [7:0]   m_ctrl = 8'h00;

  always #4 clk = ~clk;

  uart_rxq u0 (.clk(clk), .rst_n(rst_n), .loopback(loopback), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_ready(rx_ready), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ctrl_q(ctrl_q));

  function automatic int m_cap();
    return m_ctrl[0] ? 16 : 1;
  endfunction

  function automatic logic [7:0] m_lsr();
    return {1'b0, 1'b1, 1'b1, 3'b000, m_ovr, (q.size() > 0)};
  endfunction

  // returns 1 if the write empties the queue
  function automatic bit m_ctrl_write(logic [7:0] d);
    bit clr = (d[0] != m_ctrl[0]) || (d[0] && d[1]);
    if (clr) q.delete();
    m_ctrl = d[0] ? (d & 8'hC9) : 8'h00;
    return clr;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one bus cycle: optional write/read plus optional receiver byte
  task automatic cyc(bit w, bit r, logic [2:0] a, logic [7:0] d,
                     bit rv, logic [7:0] rb, string req);
    logic [7:0] exp;
    bit clr = 0;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; rx_valid = rv; rx_byte = rb;
    #3;
    check({req, " rx_ready"}, {7'd0, rx_ready}, {7'd0, q.size() < m_cap()});
    if (r) begin
      exp = (a == 3'd0) ? ((q.size() > 0) ? q[0] : 8'hFF) :
            (a == 3'd5) ? m_lsr() : 8'h00;
      check(req, rdata, exp);
    end
    @(posedge clk);
    #1;
    wr_en = 0; rd_en = 0; rx_valid = 0;
    if (r && a == 3'd0 && q.size() > 0) void'(q.pop_front());
    if (r && a == 3'd5) m_ovr = 0;
    if (w && a == 3'd2) clr = m_ctrl_write(d);
    if (w && a == 3'd0 && loopback) begin
      if (q.size() < m_cap()) q.push_back(d); else m_ovr = 1;
    end
    if (rv && !loopback && !clr && q.size() < m_cap()) q.push_back(rb);
    check({req, " ctrl"}, ctrl_q, m_ctrl);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d, string req);
    cyc(1, 0, a, d, 0, 8'h00, req);
  endtask
  task automatic rd(logic [2:0] a, string req);
    cyc(0, 1, a, 8'h00, 0, 8'h00, req);
  endtask
  task automatic rx(logic [7:0] b, string req);
    cyc(0, 0, 3'd0, 8'h00, 1, b, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(3'd5, "R1 lsr after reset");
    check("R1 ctrl after reset", ctrl_q, 8'h00);
    // R10 empty pop
    rd(3'd0, "R10 empty pop");
    rd(3'd5, "R10 still empty");
    // R2 legacy capacity one; R7 drop on full without overrun
    rx(8'hA1, "R2 legacy push");
    rx(8'hA2, "R7 legacy full drop");
    rd(3'd5, "R7 no overrun");
    // R11 push+pop on full legacy queue
    cyc(0, 1, 3'd0, 8'h00, 1, 8'hB7, "R11 legacy swap");
    rd(3'd5, "R11 legacy lsr");
    rd(3'd0, "R11 new byte");
    // R3 enable flips, clear beats same-cycle receiver byte
    rx(8'h33, "R3 prefill");
    cyc(1, 0, 3'd2, 8'h01, 1, 8'h44, "R3 enable with rx");
    rd(3'd5, "R3 empty after flip");
    // R2 fill sixteen, check order
    for (int i = 0; i < 16; i++) rx(8'h10 + 8'(i), "R2 fill");
    rx(8'hEE, "R7 wide full drop");
    // R11 on full sixteen
    cyc(0, 1, 3'd0, 8'h00, 1, 8'hCC, "R11 wide swap");
    rd(3'd5, "R11 wide lsr");
    for (int i = 0; i < 16; i++) rd(3'd0, "R2 order");
    // R5 mask and receiver reset
    wr(3'd2, 8'hFD, "R5 mask");
    rx(8'h55, "R5 prefill");
    wr(3'd2, 8'h0B, "R5 rx reset");
    rd(3'd5, "R5 empty");
    cyc(1, 0, 3'd2, 8'hC9, 1, 8'h66, "R5 no-clear write keeps push");
    rd(3'd0, "R5 byte kept");
    // R4 disable stores zero
    wr(3'd2, 8'hFE, "R4 disable");
    // R6 loopback: writes push, rx ignored, overrun on full
    loopback = 1'b1;
    rx(8'h77, "R6 rx ignored");
    rd(3'd5, "R6 still empty");
    wr(3'd0, 8'h81, "R6 lb push");
    wr(3'd0, 8'h82, "R6 lb overflow");
    // R9 write to lsr ignored, read clears overrun
    wr(3'd5, 8'h00, "R9 lsr write");
    rd(3'd5, "R8 lsr with overrun");
    rd(3'd5, "R9 overrun cleared");
    rd(3'd0, "R6 lb byte");
    loopback = 1'b0;

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom_range(0, 99);
      if (sel < 3) loopback = ~loopback;
      else if (sel < 30) rx(8'($urandom), "R2 rand rx");
      else if (sel < 50) rd(3'd0, "R2 rand pop");
      else if (sel < 60) rd(3'd5, "R8 rand lsr");
      else if (sel < 72) cyc(0, 1, 3'd0, 8'h00, 1, 8'($urandom), "R11 rand swap");
      else if (sel < 82) wr(3'd0, 8'($urandom), "R6 rand data write");
      else if (sel < 86) cyc(1, 0, 3'd2, 8'($urandom) | 8'h01, $urandom_range(0,1) == 1,
                              8'($urandom), "R3 rand ctrl");
      else if (sel < 88) cyc(1, 0, 3'd2, 8'($urandom), 1, 8'($urandom), "R4 rand ctrl");
      else if (sel < 92) wr(3'd2, {$urandom_range(0,1) == 1 ? 2'b11 : 2'b00, 4'b0, 2'b01},
                             "R5 rand keep");
      else cyc(1, 0, 3'd5, 8'($urandom), 1, 8'($urandom), "R9 rand lsr write");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule